// File: doc/BRIEF.md
# Stereo Merged Bitstream Serializer

This block turns pairs of parallel 16-bit audio samples into a single serial stream that carries both channels. For each pair it sends the left word and then the right word, each most significant bit first, on one data line. The same logic generates three framing clocks from the system clock: a bit clock, a channel clock at the frame rate, and a word clock at twice the frame rate. The word clock completes one cycle per channel word.

Samples enter through a valid/ready handshake. The block offers to take a new pair only once per frame, at the frame boundary. If no pair is offered there, it sends the previous pair again and raises an underrun flag for that frame. A matching deserializer is included for loopback checking. It watches a serial data line, a bit clock and a channel clock, uses the channel clock transitions to find the word boundaries, rebuilds the left and right words, and flags any word that does not hold exactly 16 bits.

Top module: `stereo_stream_link`

## Requirements
- R1: During and right after reset, bit_clk is 1, lr_clk is 0, word_clk is 0, ser_data is 0, in_ready is 0, underrun is 0, rx_valid is 0 and rx_frame_err is 0.
- R2: bit_clk holds each level for exactly HALF_DIV system clock cycles, so one bit period is 2*HALF_DIV cycles and one frame is 32 bit periods.
- R3: Each frame carries 32 bits: left[15] down to left[0], then right[15] down to right[0]. ser_data changes only in the cycle in which bit_clk falls, so it is stable when bit_clk rises.
- R4: lr_clk is 1 for the 16 bit periods of the left word and 0 for the 16 bit periods of the right word. It changes only together with a falling edge of bit_clk, and that edge is the one that puts out the word's MSB.
- R5: word_clk is 1 for the first 8 bit periods of each word and 0 for the last 8. It rises together with lr_clk at the start of every frame and rises again at the start of the right word.
- R6: in_ready is a single-cycle pulse in the system clock cycle just before the frame-boundary falling edge of bit_clk. A pair with in_valid high in that cycle is accepted, and its left MSB is the first bit of the frame that starts on that edge.
- R7: If in_valid is low while in_ready is high, the pair sent last is sent again and underrun is 1 for that whole frame. underrun returns to 0 at the next frame whose pair is accepted.
- R8: The deserializer starts a new word at each rising edge of rx_bclk at which rx_lrclk differs from its level at the previous rising edge. When a right word (rx_lrclk 0) closes and both it and the left word before it held 16 bits, rx_valid pulses for one cycle with the pair on rx_left and rx_right.
- R9: When a word closes with a bit count other than 16, rx_frame_err pulses for one cycle and that frame gives no rx_valid. The partial word before the first channel clock transition after reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_left | input | 16 | Left sample offered |
| in_right | input | 16 | Right sample offered |
| in_valid | input | 1 | Offered pair is valid |
| in_ready | output | 1 | Frame-boundary accept strobe |
| ser_data | output | 1 | Merged serial data, MSB first |
| bit_clk | output | 1 | Serial bit clock |
| lr_clk | output | 1 | Channel clock, 1 = left word |
| word_clk | output | 1 | Word clock, one cycle per word |
| underrun | output | 1 | Current frame repeats the previous pair |
| rx_sdata | input | 1 | Deserializer serial data |
| rx_bclk | input | 1 | Deserializer bit clock |
| rx_lrclk | input | 1 | Deserializer channel clock |
| rx_left | output | 16 | Recovered left word |
| rx_right | output | 16 | Recovered right word |
| rx_valid | output | 1 | Recovered pair strobe |
| rx_frame_err | output | 1 | Word length error strobe |

## Verification
The bench sends patterns with single set bits at both ends of each word, alternating bits and all ones against all zeros. A design that swaps the channels, sends LSB first or drops the edge bits fails the bit comparison. It holds back a pair at one boundary to force a repeat, which catches a design that sends stale zeros or never sets or clears the underrun flag. It also drives the deserializer by hand with a 15-bit left word and a 17-bit right word. A deserializer that counts words wrongly, reports a pair built around a bad word, or flags the unaligned word after reset shows wrong strobe counts.

// File: rtl/stereo_link_pkg.sv
package stereo_link_pkg;

  // Channel clock level for a bit position within the frame: left word first.
  function automatic logic lr_level(input int unsigned idx, input int unsigned word_w);
    return idx < word_w;
  endfunction

  // Word clock level: high for the first half of every word.
  function automatic logic wd_level(input int unsigned idx, input int unsigned word_w);
    return (idx % word_w) < (word_w / 2);
  endfunction

endpackage

// File: rtl/stereo_link_clkgen.sv
module stereo_link_clkgen #(
  parameter int HALF_DIV   = 2,
  parameter int FRAME_BITS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic                          bit_clk,
  output logic [$clog2(FRAME_BITS)-1:0] bit_idx,
  output logic                          fall_evt,
  output logic                          frame_evt
);
  localparam int PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [PW-1:0] PLAST = PW'(HALF_DIV - 1);
  localparam logic [CW-1:0] ILAST = CW'(FRAME_BITS - 1);

  logic [PW-1:0] pcnt;
  logic          tick;

  assign tick      = (pcnt == PLAST);
  assign fall_evt  = tick & bit_clk;
  assign frame_evt = fall_evt & (bit_idx == ILAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt    <= '0;
      bit_clk <= 1'b1;
      bit_idx <= ILAST;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) bit_clk <= ~bit_clk;
      if (fall_evt) bit_idx <= (bit_idx == ILAST) ? '0 : bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/stereo_link_txshift.sv
module stereo_link_txshift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_evt,
  input  logic              frame_evt,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  input  logic              in_valid,
  output logic              ser_data,
  output logic              underrun
);
  localparam int FW = 2 * WORD_W;

  logic [WORD_W-1:0] hold_l, hold_r;
  logic [FW-1:0]     shreg;

  assign ser_data = shreg[FW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l   <= '0;
      hold_r   <= '0;
      shreg    <= '0;
      underrun <= 1'b0;
    end else if (frame_evt) begin
      if (in_valid) begin
        hold_l   <= in_left;
        hold_r   <= in_right;
        shreg    <= {in_left, in_right};
        underrun <= 1'b0;
      end else begin
        shreg    <= {hold_l, hold_r};
        underrun <= 1'b1;
      end
    end else if (fall_evt) begin
      shreg <= {shreg[FW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/stereo_link_deser.sv
module stereo_link_deser #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_sdata,
  input  logic              rx_bclk,
  input  logic              rx_lrclk,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid,
  output logic              rx_frame_err
);
  localparam int NW = $clog2(WORD_W) + 2;
  localparam logic [NW-1:0] NMAX  = '1;
  localparam logic [NW-1:0] NWORD = NW'(WORD_W);

  logic              bclk_q, lr_last, synced, left_ok;
  logic [WORD_W-1:0] sh, left_buf;
  logic [NW-1:0]     nbits;
  logic              rise, boundary, word_ok;

  assign rise     = rx_bclk & ~bclk_q;
  assign boundary = rise & (rx_lrclk != lr_last);
  assign word_ok  = (nbits == NWORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q       <= 1'b0;
      lr_last      <= 1'b0;
      synced       <= 1'b0;
      left_ok      <= 1'b0;
      sh           <= '0;
      left_buf     <= '0;
      nbits        <= '0;
      rx_left      <= '0;
      rx_right     <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
    end else begin
      bclk_q       <= rx_bclk;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      if (rise) begin
        lr_last <= rx_lrclk;
        if (boundary) begin
          synced <= 1'b1;
          if (synced) begin
            if (!word_ok) rx_frame_err <= 1'b1;
            if (lr_last) begin
              left_ok  <= word_ok;
              left_buf <= sh;
            end else begin
              left_ok <= 1'b0;
              if (word_ok && left_ok) begin
                rx_valid <= 1'b1;
                rx_left  <= left_buf;
                rx_right <= sh;
              end
            end
          end
          sh    <= {{(WORD_W-1){1'b0}}, rx_sdata};
          nbits <= NW'(1);
        end else begin
          sh    <= {sh[WORD_W-2:0], rx_sdata};
          nbits <= (nbits == NMAX) ? nbits : nbits + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stereo_stream_link.sv
module stereo_stream_link #(
  parameter int WORD_W   = 16,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              ser_data,
  output logic              bit_clk,
  output logic              lr_clk,
  output logic              word_clk,
  output logic              underrun,
  input  logic              rx_sdata,
  input  logic              rx_bclk,
  input  logic              rx_lrclk,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid,
  output logic              rx_frame_err
);
  import stereo_link_pkg::*;

  localparam int FRAME_BITS = 2 * WORD_W;
  localparam int CW = $clog2(FRAME_BITS);

  logic [CW-1:0] bit_idx;
  logic          fall_evt, frame_evt;

  stereo_link_clkgen #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .bit_idx(bit_idx),
    .fall_evt(fall_evt), .frame_evt(frame_evt)
  );

  stereo_link_txshift #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .frame_evt(frame_evt),
    .in_left(in_left), .in_right(in_right), .in_valid(in_valid),
    .ser_data(ser_data), .underrun(underrun)
  );

  stereo_link_deser #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_sdata(rx_sdata), .rx_bclk(rx_bclk),
    .rx_lrclk(rx_lrclk), .rx_left(rx_left), .rx_right(rx_right),
    .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
  );

  assign in_ready = frame_evt;
  assign lr_clk   = lr_level(32'(bit_idx), WORD_W);
  assign word_clk = wd_level(32'(bit_idx), WORD_W);
endmodule

// File: rtl/stereo_stream_link_chk.sv
module stereo_stream_link_chk #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic ser_data,
  input logic bit_clk,
  input logic lr_clk,
  input logic word_clk,
  input logic underrun,
  input logic rx_valid,
  input logic rx_frame_err
);
  logic        prev_bclk;
  logic [15:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_bclk <= 1'b1;
      run       <= '0;
    end else begin
      prev_bclk <= bit_clk;
      run       <= (bit_clk != prev_bclk) ? 16'd1 : run + 16'd1;
    end
  end

  // R2
  bitclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_clk != prev_bclk) |-> (run == 16'(HALF_DIV)));
  // R3
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data) |-> $fell(bit_clk));
  // R4
  lr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lr_clk) |-> $fell(bit_clk));
  // R5
  wd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lr_clk) |-> $rose(word_clk));
  // R6
  accept_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (lr_clk && word_clk && $fell(bit_clk)));
  // R7
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> underrun);
  // R7
  underrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> !underrun);
  // R9
  rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_frame_err));
endmodule

bind stereo_stream_link stereo_stream_link_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .ser_data(ser_data), .bit_clk(bit_clk), .lr_clk(lr_clk), .word_clk(word_clk),
  .underrun(underrun), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
);

// File: tb/test_stereo_stream_link.sv
module test_stereo_stream_link;
  localparam int HALF = 2;
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'h8000_0001, 32'hFFFF_0000, 32'hA5A5_5A5A,
    32'h1234_FEDC, 32'h0000_FFFF, 32'h0001_8000
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] in_left = '0, in_right = '0;
  logic in_valid = 1'b0;
  logic in_ready, ser_data, bit_clk, lr_clk, word_clk, underrun;
  logic [15:0] rx_left, rx_right;
  logic rx_valid, rx_frame_err;
  logic loop_en = 1'b0, inj_d = 1'b0, inj_b = 1'b0, inj_lr = 1'b0;
  logic rx_sdata, rx_bclk, rx_lrclk;
  int checks = 0, errors = 0, rx_cnt = 0, err_cnt = 0;
  logic [31:0] last_rx = '0;

  assign rx_sdata = loop_en ? ser_data : inj_d;
  assign rx_bclk  = loop_en ? bit_clk  : inj_b;
  assign rx_lrclk = loop_en ? lr_clk   : inj_lr;

  always #2.5 clk = ~clk;

  stereo_stream_link #(.WORD_W(16), .HALF_DIV(HALF)) i_stereo_stream_link (
    .clk(clk), .rst_n(rst_n), .in_left(in_left), .in_right(in_right),
    .in_valid(in_valid), .in_ready(in_ready), .ser_data(ser_data),
    .bit_clk(bit_clk), .lr_clk(lr_clk), .word_clk(word_clk), .underrun(underrun),
    .rx_sdata(rx_sdata), .rx_bclk(rx_bclk), .rx_lrclk(rx_lrclk),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      rx_cnt++;
      last_rx = {rx_left, rx_right};
    end
    if (rst_n && rx_frame_err) err_cnt++;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Captures one frame at the bit clock rising edges, checking framing on the way.
  task automatic capture(output logic [31:0] bits, output logic ur);
    logic lr_ok = 1'b1, wd_ok = 1'b1, per_ok = 1'b1;
    for (int k = 0; k < 32; k++) begin
      int gap = 0;
      do begin @(negedge clk); gap++; end while (bit_clk);
      do begin @(negedge clk); gap++; end while (!bit_clk);
      if (k > 0 && gap != 2 * HALF) per_ok = 1'b0;
      if (k == 0) ur = underrun;
      bits[31-k] = ser_data;
      if (lr_clk != (k < 16)) lr_ok = 1'b0;
      if (word_clk != ((k % 16) < 8)) wd_ok = 1'b0;
    end
    chk(per_ok, "R2 bit period", 32'(per_ok), 32'd1);
    chk(lr_ok, "R4 lr_clk per bit", 32'(lr_ok), 32'd1);
    chk(wd_ok, "R5 word_clk per bit", 32'(wd_ok), 32'd1);
  endtask

  task automatic inj_bit(input logic d, input logic lr);
    @(negedge clk); inj_b = 1'b0; inj_d = d; inj_lr = lr;
    repeat (2) @(negedge clk);
    inj_b = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic inj_word(input logic [16:0] w, input int n, input logic lr);
    for (int i = n - 1; i >= 0; i--) inj_bit(w[i], lr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic ur;
    int base;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(bit_clk && !lr_clk && !word_clk && !ser_data && !in_ready && !underrun
        && !rx_valid && !rx_frame_err, "R1 reset outputs",
        {24'd0, bit_clk, lr_clk, word_clk, ser_data, in_ready, underrun, rx_valid, rx_frame_err},
        32'h80);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_clk && !lr_clk && !word_clk, "R1 after release",
        {29'd0, bit_clk, lr_clk, word_clk}, 32'h4);

    // R9 / R8 hand-driven deserializer: good, short left, good, long right
    inj_word(17'h0C3A5, 16, 1'b1);
    inj_word(17'h05AF0, 16, 1'b0);
    inj_word(17'h07FFF, 15, 1'b1);
    chk(rx_cnt == 1 && last_rx == 32'hC3A5_5AF0, "R8 injected good frame", last_rx, 32'hC3A5_5AF0);
    chk(err_cnt == 0, "R9 no error on first unaligned word", 32'(err_cnt), 32'd0);
    inj_word(17'h01111, 16, 1'b0);
    chk(err_cnt == 1, "R9 short left word flagged", 32'(err_cnt), 32'd1);
    inj_word(17'h02468, 16, 1'b1);
    chk(rx_cnt == 1, "R9 bad frame gives no rx_valid", 32'(rx_cnt), 32'd1);
    inj_word(17'h1ACE1, 17, 1'b0);
    chk(err_cnt == 1, "R9 good left word not flagged", 32'(err_cnt), 32'd1);
    inj_word(17'h09999, 16, 1'b1);
    inj_word(17'h03333, 16, 1'b0);
    inj_bit(1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk(err_cnt == 2, "R9 long right word flagged", 32'(err_cnt), 32'd2);
    chk(rx_cnt == 2 && last_rx == 32'h9999_3333, "R8 frame after errors", last_rx, 32'h9999_3333);

    // Loopback run from a fresh reset
    rst_n = 1'b0; loop_en = 1'b1;
    {in_left, in_right} = VEC[0]; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    base = rx_cnt;
    err_cnt = 0;
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {in_left, in_right} = VEC[i]; in_valid = 1'b1;
      do @(negedge clk); while (!in_ready);
      @(negedge clk);
      in_valid = 1'b0;
      chk(!in_ready, "R6 in_ready single cycle", 32'(in_ready), 32'd0);
      capture(got, ur);
      chk(got == VEC[i], "R3 frame bits", got, VEC[i]);
      chk(!ur, "R7 no underrun when fed", 32'(ur), 32'd0);
      if (i > 0)
        chk(rx_cnt - base == i && last_rx == VEC[i-1], "R8 loopback pair", last_rx, VEC[i-1]);
    end

    // R7 underrun: nothing offered at the boundary
    do @(negedge clk); while (!in_ready);
    @(negedge clk);
    capture(got, ur);
    chk(got == VEC[NV-1], "R7 repeated pair", got, VEC[NV-1]);
    chk(ur, "R7 underrun set", 32'(ur), 32'd1);
    {in_left, in_right} = 32'h7E81_0FF0; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(negedge clk);
    in_valid = 1'b0;
    capture(got, ur);
    chk(got == 32'h7E81_0FF0, "R6 pair after underrun", got, 32'h7E81_0FF0);
    chk(!ur, "R7 underrun cleared", 32'(ur), 32'd0);
    chk(last_rx == VEC[NV-1], "R8 repeated pair received", last_rx, VEC[NV-1]);
    chk(err_cnt == 0, "R9 no loopback errors", 32'(err_cnt), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule